// File: doc/BRIEF.md
# Infrared Frame Opening-Sequence Generator

This block produces the bytes that open an infrared frame, ahead of the payload. A start pulse hands it an 8-bit length setting and a mode bit, and it streams the opening sequence to a downstream serializer over a valid/ready byte interface. Once the last opening byte is taken, it pulses a done flag so that the payload path can take over.

In the slow, byte-oriented mode, the length setting is the total number of beginning-of-frame bytes. That total includes the one mandatory beginning byte (0xC0). Any extra preamble bytes (0xFF) go out before it. A setting of zero wraps to the longest sequence: 255 extras, then the beginning byte. In the medium-rate, bit-oriented mode, every byte is an opening flag (0x7E). The setting counts flags beyond a fixed minimum of two.

The setting and mode are captured when the start pulse arrives. Input changes while a sequence is in flight do not affect it.

Top module: `irda_preamble_gen`

## Requirements
- R1: After reset, and while no sequence is in flight, `busy`, `out_valid` and `done` are all 0. A reset during a sequence abandons it and returns these outputs to 0.
- R2: With `cfg_mode`=0 (slow) and `cfg_count`=N for N in 1..255, exactly N bytes are accepted: N-1 bytes of 0xFF, then one byte of 0xC0. This covers 176 extras at N=177.
- R3: With `cfg_mode`=0 and `cfg_count`=0, exactly 256 bytes are accepted: 255 bytes of 0xFF, then 0xC0.
- R4: With `cfg_mode`=1 (medium rate) and `cfg_count`=M, exactly M+2 bytes are accepted, all 0x7E. M=0 gives 2 flags.
- R5: `cfg_count` and `cfg_mode` are sampled only on the clock edge where `start` is 1 while `busy` is 0. Changes to `start`, `cfg_count` or `cfg_mode` during a sequence do not change its length or contents, and do not begin a new sequence.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_byte` holds its value and `out_valid` stays 1 into the next cycle.
- R7: `done` is 1 for exactly one cycle: the cycle after the edge that accepts the last opening byte. `busy` and `out_valid` are 0 in that cycle.
- R8: A `start` pulse sampled while idle raises `busy` and `out_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_count | input | 8 | Length setting, captured on start |
| cfg_mode | input | 1 | 0 = slow byte mode, 1 = medium-rate flag mode |
| start | input | 1 | Begin a sequence (ignored while busy) |
| out_ready | input | 1 | Serializer can accept `out_byte` |
| out_byte | output | 8 | Current opening byte |
| out_valid | output | 1 | `out_byte` is offered |
| done | output | 1 | One-cycle pulse after the last byte is accepted |
| busy | output | 1 | Sequence in flight |

## Verification
Each result has a fixed due cycle. `busy` and `out_valid` are due one edge after `start`. Each accepted byte takes effect at the edge where `out_valid` and `out_ready` are both 1. `done` is due one edge after the last acceptance and is gone one edge later. The bench drives inputs and samples outputs at the falling edge. It decides acceptance from the `out_valid` it has just read and the `out_ready` it is driving, so every byte is compared in the cycle it is offered. The `done` check sits exactly one falling edge after the final accepting cycle, with a further check one edge later that the pulse has ended. Ready patterns with stalls test the hold rule, and a start pulse with altered settings in mid-sequence tests that the captured settings stay fixed.

// File: rtl/irda_pre_pkg.sv
package irda_pre_pkg;

    typedef enum logic {
        PRE_SLOW = 1'b0,
        PRE_MED  = 1'b1
    } pre_mode_e;

    localparam logic [7:0] SYM_EXTRA = 8'hFF;
    localparam logic [7:0] SYM_BEGIN = 8'hC0;
    localparam logic [7:0] SYM_FLAG  = 8'h7E;
    localparam int         MED_MIN_FLAGS = 2;

endpackage

// File: rtl/irda_pre_len.sv
module irda_pre_len
    import irda_pre_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0] count,
    input  pre_mode_e        mode,
    output logic [LEN_W-1:0] total
);
    // Slow mode: the setting already includes the mandatory byte; zero wraps to 2^CNT_W.
    // Medium mode: the setting is added to the fixed minimum flag count.
    always_comb begin
        if (mode == PRE_MED) begin
            total = {1'b0, count} + LEN_W'(MED_MIN_FLAGS);
        end else if (count == '0) begin
            total = {1'b1, {CNT_W{1'b0}}};
        end else begin
            total = {1'b0, count};
        end
    end
endmodule

// File: rtl/irda_pre_sym.sv
module irda_pre_sym
    import irda_pre_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  pre_mode_e        mode,
    input  logic [LEN_W-1:0] remain,
    output logic [7:0]       sym
);
    always_comb begin
        if (mode == PRE_MED) begin
            sym = SYM_FLAG;
        end else if (remain == LEN_W'(1)) begin
            sym = SYM_BEGIN;
        end else begin
            sym = SYM_EXTRA;
        end
    end
endmodule

// File: rtl/irda_preamble_gen.sv
module irda_preamble_gen
    import irda_pre_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_mode,
    input  logic             start,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_valid,
    output logic             done,
    output logic             busy
);
    localparam int LEN_W = CNT_W + 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        pre_mode_e        mode;
        logic [LEN_W-1:0] remain;
    } gen_state_t;

    gen_state_t       s_d, s_q;
    logic [LEN_W-1:0] total_w;
    pre_mode_e        mode_in;

    assign mode_in = pre_mode_e'(cfg_mode);

    irda_pre_len #(.CNT_W(CNT_W)) u_len (
        .count (cfg_count),
        .mode  (mode_in),
        .total (total_w)
    );

    irda_pre_sym #(.LEN_W(LEN_W)) u_sym (
        .mode   (s_q.mode),
        .remain (s_q.remain),
        .sym    (out_byte)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy   = 1'b1;
                s_d.mode   = mode_in;
                s_d.remain = total_w;
            end
        end else if (out_ready) begin
            if (s_q.remain == LEN_W'(1)) begin
                s_d.busy   = 1'b0;
                s_d.done   = 1'b1;
                s_d.remain = '0;
            end else begin
                s_d.remain = s_q.remain - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, done: 1'b0, mode: PRE_SLOW, remain: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.busy;
    assign busy      = s_q.busy;
    assign done      = s_q.done;
endmodule

// File: rtl/irda_pre_chk.sv
module irda_pre_chk
    import irda_pre_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       out_valid,
    input logic       done,
    input logic       busy
);
    // R6
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !out_valid));

    // R2
    begin_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_byte == SYM_BEGIN) |=> done);

    // R8
    start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && out_valid));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready));
endmodule

bind irda_preamble_gen irda_pre_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .done      (done),
    .busy      (busy)
);

// File: tb/test_irda_preamble_gen.sv
module test_irda_preamble_gen;
    localparam int CLK_P = 10;
    localparam int NVEC  = 10;
    // entry: {mode, count, ready pattern, disturb}
    localparam logic [31:0] VECS [NVEC] = '{
        {8'd0, 8'd1,   8'd0, 8'd0},
        {8'd0, 8'd2,   8'd1, 8'd0},
        {8'd0, 8'd177, 8'd0, 8'd0},
        {8'd0, 8'd0,   8'd0, 8'd0},
        {8'd0, 8'd255, 8'd2, 8'd0},
        {8'd1, 8'd0,   8'd0, 8'd0},
        {8'd1, 8'd5,   8'd1, 8'd1},
        {8'd1, 8'd255, 8'd0, 8'd0},
        {8'd0, 8'd3,   8'd2, 8'd1},
        {8'd1, 8'd1,   8'd3, 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_count = 8'd0;
    logic       cfg_mode = 1'b0;
    logic       start = 1'b0;
    logic       out_ready = 1'b0;
    logic [7:0] out_byte;
    logic       out_valid, done, busy;

    int errs = 0;
    int checks = 0;

    irda_preamble_gen i_irda_preamble_gen (
        .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_mode(cfg_mode),
        .start(start), .out_ready(out_ready), .out_byte(out_byte),
        .out_valid(out_valid), .done(done), .busy(busy)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit rdy(input int pat, input int k);
        case (pat)
            0: return 1'b1;
            1: return k[0];
            2: return (k % 3) == 2;
            default: return k >= 6;
        endcase
    endfunction

    task automatic run_frame(input logic md, input logic [7:0] cnt, input int pat, input bit disturb);
        int total, idx, k, bad, hold_bad, bad_act, bad_exp;
        bit stalled, early_done, r;
        logic [7:0] held, expb;
        string req;
        total = md ? int'(cnt) + 2 : (cnt == 8'd0 ? 256 : int'(cnt));
        req = md ? "R4" : (cnt == 8'd0 ? "R3" : "R2");
        idx = 0; k = 0; bad = 0; hold_bad = 0; bad_act = 0; bad_exp = 0;
        stalled = 1'b0; early_done = 1'b0; held = 8'h00;
        @(negedge clk);
        cfg_mode = md; cfg_count = cnt; start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        // R8: busy and valid one edge after start
        chk(busy === 1'b1 && out_valid === 1'b1, "R8", "busy/valid after start", int'(busy), 1);
        while (idx < total && k < 3000) begin
            if (done) early_done = 1'b1;
            if (stalled && (out_byte !== held || out_valid !== 1'b1)) hold_bad++;
            r = rdy(pat, k);
            if (disturb && k == 2) begin
                start = 1'b1; cfg_count = cnt + 8'd7; cfg_mode = ~md;
            end else begin
                start = 1'b0;
            end
            out_ready = r;
            if (out_valid && r) begin
                expb = md ? 8'h7E : (idx == total - 1 ? 8'hC0 : 8'hFF);
                if (out_byte !== expb) begin
                    if (bad == 0) begin bad_act = int'(out_byte); bad_exp = int'(expb); end
                    bad++;
                end
                idx++;
                stalled = 1'b0;
            end else begin
                stalled = out_valid;
                held = out_byte;
            end
            k++;
            @(negedge clk);
        end
        out_ready = 1'b0; start = 1'b0;
        chk(idx == total, req, "bytes accepted", idx, total);
        chk(bad == 0, req, "byte value", bad_act, bad_exp);
        // R7: done in the cycle after last acceptance, with busy low
        chk(done === 1'b1 && busy === 1'b0 && out_valid === 1'b0, "R7", "done after last byte", int'(done), 1);
        chk(!early_done, "R7", "no early done", int'(early_done), 0);
        @(negedge clk);
        chk(done === 1'b0, "R7", "done is one cycle", int'(done), 0);
        if (pat != 0) chk(hold_bad == 0, "R6", "byte held under stall", hold_bad, 0);
        // R5: mid-sequence start did not launch a new sequence
        if (disturb) chk(busy === 1'b0, "R5", "no relaunch from start while busy", int'(busy), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        errs++; checks++;
        $display("FAIL watchdog: run hung actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R1", "reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && done === 1'b0, "R1", "idle with ready high", int'(out_valid), 0);
        out_ready = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i][24], VECS[i][23:16], int'(VECS[i][15:8]), VECS[i][0]);
        end

        // R1: reset in mid-sequence abandons it
        @(negedge clk);
        cfg_mode = 1'b0; cfg_count = 8'd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R1", "reset mid-sequence", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 / R4 after reset
        run_frame(1'b1, 8'd2, 0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule